// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Generation

This block is a purely combinational word shifter for the case where the shift distance comes from a register, not from an immediate field. It covers four operations: logical shift left, logical shift right, arithmetic shift right and rotate right. The distance is taken from the least significant byte of a full-width amount word. That byte can name distances well beyond the word width, so the block gives exact results and carry rules for a zero distance, a distance equal to the word width, and distances past it.

A mode input chooses between two behaviours. In flag-setting mode, the block computes the carry that the downstream status logic should load. In plain mode, it only produces the shifted word and reports that no carry was produced. When a flag-setting operation leaves the carry untouched, the incoming carry is passed through and the valid strobe stays high. The flag register can therefore load on every flag-setting operation without extra decode.

Top module: `shf_reg_shifter`

## Requirements
- R1: Only bits [7:0] of `amount_i` form the shift distance n. Any value on bits [31:8] gives the same outputs as when those bits are zero.
- R2: When n is 0, every operation returns `operand_i` unchanged. In flag mode, `carry_o` equals `carry_i`.
- R3: Logical left (`op_i` = 2'b00). For n in 1..31 the result is operand << n and the carry is operand bit (32-n). For n = 32 the result is 0 and the carry is operand bit 0. For n > 32 both the result and the carry are 0.
- R4: Logical right (`op_i` = 2'b01). For n in 1..31 the result is operand >> n and the carry is operand bit (n-1). For n = 32 the result is 0 and the carry is operand bit 31. For n > 32 both the result and the carry are 0.
- R5: Arithmetic right (`op_i` = 2'b10). For n in 1..31 the result is the sign-extending shift and the carry is operand bit (n-1). For n ≥ 32 every result bit equals operand bit 31, and the carry is operand bit 31.
- R6: Rotate right (`op_i` = 2'b11). The operand is rotated by r = n mod 32. When r ≠ 0 the carry is operand bit (r-1). When r = 0 and n ≠ 0, the result is the operand and the carry is operand bit 31.
- R7: In plain mode (`set_flags_i` = 0), the result follows the same rules as R3–R6. `carry_valid_o` is 0 and `carry_o` equals `carry_i`.
- R8: In flag mode (`set_flags_i` = 1), `carry_valid_o` is 1 for every operation and distance, including the cases where the carry is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Word to be shifted |
| amount_i | input | 32 | Register holding the shift distance; only the low byte is used |
| carry_i | input | 1 | Present carry flag |
| op_i | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| set_flags_i | input | 1 | 1 selects flag-setting mode |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Carry for the flag register |
| carry_valid_o | output | 1 | High when carry_o is meant to be loaded |

## Verification
Each operation is tried in both modes with random operands at the distances 0, 1, 31, 32, 33 and 255, plus random distances. The distances 0, 32 and 33 separate the keep-carry, exact-width and beyond-width branches, which differ only in the carry. The value 255 catches a decoder that looks at fewer than eight bits. Rotate by 32 and 64 separates the "low five bits zero but distance nonzero" case from a true zero. Amount words with random upper bits show that bits [31:8] are ignored, and sign-set operands separate arithmetic fill from logical fill.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SHF_LSL = 2'd0,
    SHF_LSR = 2'd1,
    SHF_ASR = 2'd2,
    SHF_ROR = 2'd3
  } shf_op_e;

  // Classification of the shift distance, shared by datapath and checks
  typedef struct packed {
    logic zero;      // distance is zero
    logic eq_w;      // distance equals the word width
    logic gt_w;      // distance exceeds the word width
    logic rot_zero;  // rotate distance (mod width) is zero
  } shf_amt_t;

endpackage

// File: rtl/shf_amt_class.sv
module shf_amt_class #(
  parameter int WIDTH    = 32,
  parameter int AMT_BITS = 8
) (
  input  logic [AMT_BITS-1:0]        amt_i,
  output shf_pkg::shf_amt_t          cls_o,
  output logic [$clog2(WIDTH):0]     clamp_o,
  output logic [$clog2(WIDTH)-1:0]   rot_o
);
  localparam int LOG2W   = $clog2(WIDTH);
  localparam int CLAMP_W = LOG2W + 1;

  logic [CLAMP_W-1:0] amt_low;
  logic               amt_high;
  logic               ge_w;

  // Bits above the clamp range only matter as a "very large" indication
  generate
    if (AMT_BITS > CLAMP_W) begin : g_wide
      assign amt_low  = amt_i[CLAMP_W-1:0];
      assign amt_high = |amt_i[AMT_BITS-1:CLAMP_W];
    end else begin : g_narrow
      assign amt_low  = CLAMP_W'(amt_i);
      assign amt_high = 1'b0;
    end
  endgenerate

  always_comb begin
    ge_w           = amt_high || (amt_low >= CLAMP_W'(WIDTH));
    cls_o.zero     = (amt_i == '0);
    cls_o.eq_w     = !amt_high && (amt_low == CLAMP_W'(WIDTH));
    cls_o.gt_w     = ge_w && !cls_o.eq_w;
    rot_o          = amt_i[LOG2W-1:0];
    cls_o.rot_zero = (rot_o == '0);
    clamp_o        = ge_w ? CLAMP_W'(WIDTH) : amt_low;
  end

endmodule

// File: rtl/shf_datapath.sv
module shf_datapath #(
  parameter int WIDTH = 32
) (
  input  shf_pkg::shf_op_e           op_i,
  input  logic [WIDTH-1:0]           x_i,
  input  shf_pkg::shf_amt_t          cls_i,
  input  logic [$clog2(WIDTH):0]     clamp_i,
  input  logic [$clog2(WIDTH)-1:0]   rot_i,
  output logic [WIDTH-1:0]           res_o,
  output logic                       shifted_carry_o,
  output logic                       keep_carry_o
);
  import shf_pkg::*;
  localparam int LOG2W = $clog2(WIDTH);

  // Left: an extra top bit catches the last bit shifted out
  function automatic logic [WIDTH:0] f_lsl(input logic [WIDTH-1:0] x,
                                           input logic [LOG2W:0] n);
    return {1'b0, x} << n;
  endfunction

  // Right logical: an extra bottom bit catches the last bit shifted out
  function automatic logic [WIDTH:0] f_lsr(input logic [WIDTH-1:0] x,
                                           input logic [LOG2W:0] n);
    return {x, 1'b0} >> n;
  endfunction

  function automatic logic [WIDTH:0] f_asr(input logic [WIDTH-1:0] x,
                                           input logic [LOG2W:0] n);
    return $unsigned($signed({x, 1'b0}) >>> n);
  endfunction

  function automatic logic [WIDTH-1:0] f_ror(input logic [WIDTH-1:0] x,
                                             input logic [LOG2W-1:0] r);
    logic [2*WIDTH-1:0] dbl;
    dbl = {x, x} >> r;
    return dbl[WIDTH-1:0];
  endfunction

  logic [WIDTH:0]   lsl_w, lsr_w, asr_w;
  logic [WIDTH-1:0] ror_w;

  assign lsl_w = f_lsl(x_i, clamp_i);
  assign lsr_w = f_lsr(x_i, clamp_i);
  assign asr_w = f_asr(x_i, clamp_i);
  assign ror_w = f_ror(x_i, rot_i);

  assign keep_carry_o = cls_i.zero;

  always_comb begin
    res_o           = x_i;
    shifted_carry_o = 1'b0;
    unique case (op_i)
      SHF_LSL: begin
        res_o           = lsl_w[WIDTH-1:0];
        shifted_carry_o = lsl_w[WIDTH] && !cls_i.gt_w;
      end
      SHF_LSR: begin
        res_o           = lsr_w[WIDTH:1];
        shifted_carry_o = lsr_w[0] && !cls_i.gt_w;
      end
      SHF_ASR: begin
        res_o           = asr_w[WIDTH:1];
        shifted_carry_o = asr_w[0];
      end
      SHF_ROR: begin
        // the bit rotated out last lands in the top position
        res_o           = ror_w;
        shifted_carry_o = ror_w[WIDTH-1];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/shf_flag_sel.sv
module shf_flag_sel (
  input  logic set_flags_i,
  input  logic carry_i,
  input  logic shifted_carry_i,
  input  logic keep_carry_i,
  output logic carry_o,
  output logic carry_valid_o
);
  always_comb begin
    carry_valid_o = set_flags_i;
    if (set_flags_i && !keep_carry_i) carry_o = shifted_carry_i;
    else                              carry_o = carry_i;
  end
endmodule

// File: rtl/shf_reg_shifter.sv
module shf_reg_shifter #(
  parameter int WIDTH    = 32,
  parameter int AMT_BITS = 8
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [WIDTH-1:0] amount_i,
  input  logic             carry_i,
  input  logic [1:0]       op_i,
  input  logic             set_flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             carry_valid_o
);
  import shf_pkg::*;
  localparam int LOG2W = $clog2(WIDTH);

  shf_amt_t          amt_cls;
  logic [LOG2W:0]    amt_clamp;
  logic [LOG2W-1:0]  amt_rot;
  logic              shifted_carry;
  logic              keep_carry;
  shf_op_e           op;

  assign op = shf_op_e'(op_i);

  shf_amt_class #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS)) u_class (
    .amt_i   (amount_i[AMT_BITS-1:0]),
    .cls_o   (amt_cls),
    .clamp_o (amt_clamp),
    .rot_o   (amt_rot)
  );

  shf_datapath #(.WIDTH(WIDTH)) u_dp (
    .op_i            (op),
    .x_i             (operand_i),
    .cls_i           (amt_cls),
    .clamp_i         (amt_clamp),
    .rot_i           (amt_rot),
    .res_o           (result_o),
    .shifted_carry_o (shifted_carry),
    .keep_carry_o    (keep_carry)
  );

  shf_flag_sel u_flag (
    .set_flags_i     (set_flags_i),
    .carry_i         (carry_i),
    .shifted_carry_i (shifted_carry),
    .keep_carry_i    (keep_carry),
    .carry_o         (carry_o),
    .carry_valid_o   (carry_valid_o)
  );

  // Checks across the decoder, datapath and flag selection
  always_comb begin
    AST_ZERO_PASS: assert (!amt_cls.zero || (result_o == operand_i && carry_o == carry_i)); // R2
    AST_LSL_BEYOND: assert (!(op == SHF_LSL && amt_cls.gt_w) || (result_o == '0 && (!set_flags_i || !carry_o))); // R3
    AST_LSR_BEYOND: assert (!(op == SHF_LSR && amt_cls.gt_w) || (result_o == '0 && (!set_flags_i || !carry_o))); // R4
    AST_ASR_FILL: assert (!(op == SHF_ASR && (amt_cls.eq_w || amt_cls.gt_w)) || (result_o == {WIDTH{operand_i[WIDTH-1]}})); // R5
    AST_ROR_WHOLE: assert (!(op == SHF_ROR && amt_cls.rot_zero) || result_o == operand_i); // R6
    AST_PLAIN_KEEP: assert (set_flags_i || (!carry_valid_o && carry_o == carry_i)); // R7
    AST_FLAG_VALID: assert (!set_flags_i || carry_valid_o); // R8
  end

endmodule

// File: tb/shf_reg_shifter_bench.sv
module shf_reg_shifter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] operand, amount;
  logic        cin, fm;
  logic [1:0]  op;
  logic [31:0] result;
  logic        cout, cvalid;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  shf_reg_shifter u_shf_reg_shifter (
    .operand_i     (operand),
    .amount_i      (amount),
    .carry_i       (cin),
    .op_i          (op),
    .set_flags_i   (fm),
    .result_o      (result),
    .carry_o       (cout),
    .carry_valid_o (cvalid)
  );

  // Reference: one bit position per step, as many steps as the distance
  task automatic ref_model(input logic [31:0] x, input logic [31:0] a, input logic ci,
                           input logic [1:0] o, input logic f,
                           output logic [31:0] r, output logic c, output logic v);
    int n = int'(a[7:0]);
    logic [31:0] w = x;
    logic cc = ci;
    case (o)
      2'd0: for (int k = 0; k < n; k++) begin cc = w[31]; w = w << 1; end
      2'd1: for (int k = 0; k < n; k++) begin cc = w[0];  w = w >> 1; end
      2'd2: for (int k = 0; k < n; k++) begin cc = w[0];  w = {w[31], w[31:1]}; end
      default: begin
        for (int k = 0; k < n % 32; k++) begin cc = w[0]; w = {w[0], w[31:1]}; end
        if (n != 0 && n % 32 == 0) cc = x[31];
      end
    endcase
    r = w;
    c = f ? cc : ci;
    v = f;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (op %0d amt %h x %h fm %0b)",
               tag, what, act, exp, op, amount, operand, fm);
    end
  endtask

  task automatic apply(input logic [31:0] x, input logic [31:0] a, input logic ci,
                       input logic [1:0] o, input logic f);
    logic [31:0] er;
    logic ec, ev;
    string tag;
    @(posedge clk);
    #1;
    operand = x; amount = a; cin = ci; op = o; fm = f;
    @(negedge clk);
    ref_model(x, a, ci, o, f, er, ec, ev);
    if (a[7:0] == 8'd0)   tag = "R2";
    else if (o == 2'd0)   tag = "R3";
    else if (o == 2'd1)   tag = "R4";
    else if (o == 2'd2)   tag = "R5";
    else                  tag = "R6";
    check(tag, "result", result, er);
    check(f ? tag : "R7", "carry", {31'd0, cout}, {31'd0, ec});
    check(f ? "R8" : "R7", "valid", {31'd0, cvalid}, {31'd0, ev});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r_low, r_high;
    int amts[6] = '{0, 1, 31, 32, 33, 255};
    operand = '0; amount = '0; cin = 1'b0; op = 2'd0; fm = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state after reset: zero in, zero out
    apply(32'd0, 32'd0, 1'b0, 2'd0, 1'b0);

    // corner distances, every op, both modes, both carry-in values
    for (int o = 0; o < 4; o++)
      for (int f = 0; f < 2; f++)
        for (int i = 0; i < 6; i++)
          for (int t = 0; t < 12; t++)
            apply((t == 0) ? 32'h8000_0001 : $urandom, amts[i], t[0], o[1:0], f[0]);

    // rotate distances that are whole multiples of the width (R6)
    for (int f = 0; f < 2; f++) begin
      apply(32'h8765_4321, 32'd64, 1'b0, 2'd3, f[0]);
      apply(32'h1234_5678, 32'd96, 1'b1, 2'd3, f[0]);
      apply(32'h1234_5678, 32'd224, 1'b1, 2'd3, f[0]);
    end

    // random distances with random upper amount bits (R1 with the model)
    for (int t = 0; t < 400; t++)
      apply($urandom, $urandom, t[1], t[3:2], t[0]);

    // R1: upper amount bits ignored, shown directly at the ports
    for (int o = 0; o < 4; o++) begin
      apply(32'hC0DE_F00D, 32'h0000_0005, 1'b1, o[1:0], 1'b1);
      r_low = {result[31:1], cout};
      apply(32'hC0DE_F00D, 32'hFFFF_FF05, 1'b1, o[1:0], 1'b1);
      r_high = {result[31:1], cout};
      check("R1", "upper bits", r_high, r_low);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule